// File: doc/BRIEF.md
# Four-Channel DAC Output Latch Update Controller

This block sits between the serial register file of a four-channel DAC and its conversion stage. Each channel holds two 12-bit values. The first is an input register that the host writes. The second is an output latch that drives the converter. The block decides when each input register is copied into its output latch. The 12-bit code passes through without change, whether it is two's complement (bipolar range) or straight binary (unipolar range).

A copy can be started in two ways. The first is the active-low load pin going low. The second is a software load request, which arms a self-clearing load flag. On either event, only the channels whose input register was written since the previous load event are copied. All copies happen on the same clock edge. Each channel that is copied raises a one-cycle pulse. While the pin is held low, the block is transparent: every write reaches its latch on the next clock, and software requests are discarded. A combinational readback port returns either the input register or the output latch of a selected channel.

Top module: `dac_latch_ctrl`

## Requirements
- R1: After reset, all input registers and all output latches read zero, every update pulse is low and the load flag is low.
- R2: A write while the load pin is high changes that channel's input register on the next clock edge and leaves every output latch unchanged.
- R3: On the clock edge where the load pin is first sampled low, each channel written since the last load event copies its input register into its latch. That channel's bit of `updPulse` is high for exactly the following cycle.
- R4: A channel not written since the last load event keeps its latch value through a load event and raises no pulse. Any change of a latch is accompanied by its pulse.
- R5: A software load request while the pin is high sets the load flag for exactly one cycle. The pending channels load on the edge that ends that cycle, and the flag then reads zero unless a new request arrives.
- R6: A software load request while the pin is low is discarded, and the load flag reads zero in the following cycle.
- R7: While the pin stays low, a write to a channel reaches that channel's latch one clock after it reaches the input register.
- R8: A write that coincides with a load edge does not enter the latch on that edge; the latch takes the earlier input value. The channel stays pending, so the next load event copies the new value.
- R9: With `rdSelLatch` at 0, `rdData` returns the input register of channel `rdChan`; with `rdSelLatch` at 1, it returns that channel's output latch.
- R10: Every 12-bit code written to any channel appears bit for bit in that channel's latch, with no sign or offset conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | NUM_CH | Per-channel write strobe for the input register |
| wrData | input | NUM_CH*DATA_W | Write data; channel n uses bits [n*DATA_W +: DATA_W] |
| ldacN | input | 1 | Active-low load pin, synchronous to clk |
| swLoadSet | input | 1 | One-cycle software load request (a 1 written to the load flag) |
| rdSelLatch | input | 1 | Readback source: 0 selects the input register, 1 selects the output latch |
| rdChan | input | CH_W | Channel selected for readback |
| latchOut | output | NUM_CH*DATA_W | Output latches; channel n uses bits [n*DATA_W +: DATA_W] |
| updPulse | output | NUM_CH | One-cycle pulse per channel whose latch was reloaded |
| swLoadPending | output | 1 | State of the self-clearing software load flag |
| rdData | output | DATA_W | Readback value |

## Verification
The assertions check three properties on every cycle. A latch never changes without its update pulse. A pulse only follows a cycle in which the pin was low or the load flag was set. The load flag never survives a cycle on its own and never stays set while the pin is low. Some behaviour can only be shown by the bench's scenarios, because it depends on the ordering of writes and load events. This covers which channels were pending at a load, the old-versus-new value when a write meets a load edge, the one-clock lag in transparent mode and the readback source. The bench also sweeps every 12-bit code through every channel.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

  // Strobes from the load controller to the channel datapath
  typedef struct packed {
    logic loadTrig;   // copy pending channels on this edge
    logic swPending;  // software load flag state
  } ctrlStrobe_t;

endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ldacN,
  input  logic        swLoadSet,
  output ctrlStrobe_t strobe
);

  logic swPending;

  // Software flag: armed only while the pin is high, cleared after the
  // cycle in which it caused a load, dropped whenever the pin is low.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swPending <= 1'b0;
    end else if (!ldacN) begin
      swPending <= 1'b0;
    end else if (swLoadSet) begin
      swPending <= 1'b1;
    end else begin
      swPending <= 1'b0;
    end
  end

  // A low pin loads on every cycle: the first low cycle is the falling
  // edge event, and later ones give the transparent behaviour.
  always_comb begin
    strobe.loadTrig  = ~ldacN | swPending;
    strobe.swPending = swPending;
  end

endmodule

// File: rtl/dac_chan_datapath.sv
module dac_chan_datapath
  import dac_latch_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrobe_t              strobe,
  input  logic [NUM_CH-1:0]        wrEn,
  input  logic [NUM_CH*DATA_W-1:0] wrData,
  input  logic                     rdSelLatch,
  input  logic [CH_W-1:0]          rdChan,
  output logic [NUM_CH*DATA_W-1:0] latchOut,
  output logic [NUM_CH-1:0]        updPulse,
  output logic [DATA_W-1:0]        rdData
);

  logic [DATA_W-1:0] inRegArr [NUM_CH];
  logic [DATA_W-1:0] latchArr [NUM_CH];
  logic [NUM_CH-1:0] dirty;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic doLoad;
    assign doLoad = strobe.loadTrig & dirty[ch];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inRegArr[ch] <= '0;
        latchArr[ch] <= '0;
        dirty[ch]    <= 1'b0;
        updPulse[ch] <= 1'b0;
      end else begin
        if (wrEn[ch]) begin
          inRegArr[ch] <= wrData[ch*DATA_W +: DATA_W];
        end
        // A write on a load edge re-arms the channel for the next event
        if (wrEn[ch]) begin
          dirty[ch] <= 1'b1;
        end else if (strobe.loadTrig) begin
          dirty[ch] <= 1'b0;
        end
        if (doLoad) begin
          latchArr[ch] <= inRegArr[ch];
        end
        updPulse[ch] <= doLoad;
      end
    end

    assign latchOut[ch*DATA_W +: DATA_W] = latchArr[ch];
  end

  always_comb begin
    rdData = rdSelLatch ? latchArr[rdChan] : inRegArr[rdChan];
  end

endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
  import dac_latch_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        wrEn,
  input  logic [NUM_CH*DATA_W-1:0] wrData,
  input  logic                     ldacN,
  input  logic                     swLoadSet,
  input  logic                     rdSelLatch,
  input  logic [CH_W-1:0]          rdChan,
  output logic [NUM_CH*DATA_W-1:0] latchOut,
  output logic [NUM_CH-1:0]        updPulse,
  output logic                     swLoadPending,
  output logic [DATA_W-1:0]        rdData
);

  ctrlStrobe_t strobe;

  dac_load_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ldacN     (ldacN),
    .swLoadSet (swLoadSet),
    .strobe    (strobe)
  );

  dac_chan_datapath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdSelLatch (rdSelLatch),
    .rdChan     (rdChan),
    .latchOut   (latchOut),
    .updPulse   (updPulse),
    .rdData     (rdData)
  );

  assign swLoadPending = strobe.swPending;

endmodule

// File: rtl/dac_latch_chk.sv
module dac_latch_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ldacN,
  input logic                     swLoadSet,
  input logic [NUM_CH*DATA_W-1:0] latchOut,
  input logic [NUM_CH-1:0]        updPulse,
  input logic                     swLoadPending
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R4
    latch_change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(latchOut[ch*DATA_W +: DATA_W]) |-> updPulse[ch]);
  end

  // R3
  pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updPulse != '0) |-> $past(!ldacN || swLoadPending));

  // R5
  flag_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swLoadPending && !swLoadSet) |=> !swLoadPending);

  // R6
  flag_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ldacN |=> !swLoadPending);

endmodule

bind dac_latch_ctrl dac_latch_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ldacN         (ldacN),
  .swLoadSet     (swLoadSet),
  .latchOut      (latchOut),
  .updPulse      (updPulse),
  .swLoadPending (swLoadPending)
);

// File: tb/test_dac_latch_ctrl.sv
`timescale 1ns/1ps
module test_dac_latch_ctrl;

  localparam int NC = 4;
  localparam int DW = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NC-1:0]     wrEn;
  logic [NC*DW-1:0]  wrData;
  logic              ldacN;
  logic              swLoadSet;
  logic              rdSelLatch;
  logic [1:0]        rdChan;
  logic [NC*DW-1:0]  latchOut;
  logic [NC-1:0]     updPulse;
  logic              swLoadPending;
  logic [DW-1:0]     rdData;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dac_latch_ctrl #(.NUM_CH(NC), .DATA_W(DW)) i_dac_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .ldacN(ldacN),
    .swLoadSet(swLoadSet), .rdSelLatch(rdSelLatch), .rdChan(rdChan),
    .latchOut(latchOut), .updPulse(updPulse), .swLoadPending(swLoadPending),
    .rdData(rdData)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] latchOf(input int ch);
    return latchOut[ch*DW +: DW];
  endfunction

  task automatic wr(input int ch, input logic [DW-1:0] d);
    wrEn = '0;
    wrEn[ch] = 1'b1;
    wrData[ch*DW +: DW] = d;
    tick();
    wrEn = '0;
  endtask

  task automatic readBack(input logic sel, input int ch, output logic [DW-1:0] v);
    rdSelLatch = sel;
    rdChan = 2'(ch);
    #0.5;
    v = rdData;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [DW-1:0] v;
    rst_n = 1'b0; wrEn = '0; wrData = '0; ldacN = 1'b1; swLoadSet = 1'b0;
    rdSelLatch = 1'b0; rdChan = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 latches", 32'(latchOut[31:0]), 32'h0);
    check("R1 latches hi", 32'(latchOut[47:32]), 32'h0);
    check("R1 pulses", 32'(updPulse), 32'h0);
    check("R1 flag", 32'(swLoadPending), 32'h0);
    for (int ch = 0; ch < NC; ch++) begin
      readBack(1'b0, ch, v); check("R1 input readback", 32'(v), 32'h0);
    end
    @(negedge clk);

    // R2 write with pin high: inputs change, latches hold
    wr(0, 12'hABC);
    wr(2, 12'h123);
    check("R2 latches unchanged", 32'(latchOut[31:0]), 32'h0);
    check("R2 latch3 unchanged", 32'(latchOf(3)), 32'h0);
    check("R2 no pulse", 32'(updPulse), 32'h0);
    // R9 readback source selection
    readBack(1'b0, 0, v); check("R9 input ch0", 32'(v), 32'hABC);
    readBack(1'b0, 2, v); check("R9 input ch2", 32'(v), 32'h123);
    readBack(1'b1, 2, v); check("R9 latch ch2", 32'(v), 32'h0);
    @(negedge clk);

    // R3/R4 falling pin edge loads only the written channels
    ldacN = 1'b0;
    tick();
    check("R3 latch0", 32'(latchOf(0)), 32'hABC);
    check("R3 latch2", 32'(latchOf(2)), 32'h123);
    check("R4 latch1 kept", 32'(latchOf(1)), 32'h0);
    check("R4 latch3 kept", 32'(latchOf(3)), 32'h0);
    check("R3 R4 pulse mask", 32'(updPulse), 32'h5);
    readBack(1'b1, 0, v); check("R9 latch ch0", 32'(v), 32'hABC);
    @(negedge clk);
    tick();
    check("R3 pulse one cycle", 32'(updPulse), 32'h0);

    // R6 software request ignored while the pin is low
    swLoadSet = 1'b1;
    tick();
    swLoadSet = 1'b0;
    check("R6 flag stays low", 32'(swLoadPending), 32'h0);
    ldacN = 1'b1;
    tick();
    check("R6 flag after pin high", 32'(swLoadPending), 32'h0);
    wr(1, 12'h555);
    tick();
    check("R6 no stale load", 32'(latchOf(1)), 32'h0);
    check("R6 no pulse", 32'(updPulse), 32'h0);

    // R5 software load
    swLoadSet = 1'b1;
    tick();
    swLoadSet = 1'b0;
    check("R5 flag set", 32'(swLoadPending), 32'h1);
    check("R5 not yet loaded", 32'(latchOf(1)), 32'h0);
    tick();
    check("R5 latch1 loaded", 32'(latchOf(1)), 32'h555);
    check("R5 pulse", 32'(updPulse), 32'h2);
    check("R5 flag cleared", 32'(swLoadPending), 32'h0);
    check("R4 latch0 kept on sw load", 32'(latchOf(0)), 32'hABC);

    // R8 write colliding with a load edge
    wr(0, 12'h111);
    swLoadSet = 1'b1;
    tick();
    swLoadSet = 1'b0;
    wr(0, 12'h222);   // edge coincides with the pending load
    check("R8 old value loaded", 32'(latchOf(0)), 32'h111);
    check("R8 pulse", 32'(updPulse), 32'h1);
    readBack(1'b0, 0, v); check("R8 input new", 32'(v), 32'h222);
    @(negedge clk);
    swLoadSet = 1'b1;
    tick();
    swLoadSet = 1'b0;
    tick();
    check("R8 new value on next load", 32'(latchOf(0)), 32'h222);
    check("R8 pulse again", 32'(updPulse), 32'h1);

    // R7 transparent mode while pin held low
    ldacN = 1'b0;
    tick();
    wr(3, 12'h7FF);
    check("R7 one clock lag", 32'(latchOf(3)), 32'h0);
    tick();
    check("R7 latch3 follows", 32'(latchOf(3)), 32'h7FF);
    check("R7 pulse", 32'(updPulse), 32'h8);

    // R10 every code through every channel (pin held low)
    for (int ch = 0; ch < NC; ch++) begin
      for (int code = 0; code < (1 << DW); code++) begin
        wr(ch, DW'(code));
        tick();
        check("R10 code passthrough", 32'(latchOf(ch)), 32'(code));
      end
    end
    for (int ch = 0; ch < NC; ch++) begin
      readBack(1'b1, ch, v);
      check("R10 R9 final latch", 32'(v), 32'((1 << DW) - 1));
    end

    finish();
  end

endmodule